// File: doc/BRIEF.md
# Cascaded Interrupt Status Controller

This block collects single-cycle event pulses from transmit, receive and management logic into two levels of sticky status. A 32-bit primary status register holds the data-path events. A 16-bit secondary status register holds management events. Each level has its own mask, where a mask bit of 1 blocks the matching status bit. Any unmasked secondary bit shows up as one summary bit in the primary status. The block drives a single level-sensitive interrupt line from the unmasked primary bits and that summary.

Software reaches the four registers through a 32-bit word-only read/write port whose local offsets are decoded here. Reading a status register returns its value and then clears it. For the primary register the summary bit is the exception: it stays set for as long as the secondary level still has unmasked bits pending. Decoding of the wider address map and the generation of the events happen elsewhere.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset both status registers read 0, the primary mask reads 0xFF7FFFFF, the secondary mask reads 0x0000FFFF and `irq` is 0.
- R2: A pulse on `ev_rx_host`, `ev_rx_nodesc`, `ev_tx_desc` or `ev_tx_empty` sets primary status bit 16, 17, 24 or 25 respectively, and that bit stays set until it is cleared.
- R3: The primary status is at offset 0x100 and the primary mask is at 0x104. Offsets 0x108 and 0x10C act exactly like 0x100 and 0x104 for both reads and writes.
- R4: A read of the primary status returns its current value and then clears every bit except bit 23.
- R5: The secondary status is at offset 0x018 and the secondary mask is at 0x014. A read of the secondary status returns its value and then clears all 16 bits.
- R6: Primary bit 23 reads 1 exactly when some secondary status bit is set while its secondary mask bit is 0. It raises `irq` whatever primary mask bit 23 holds, and a write to the primary status cannot set or clear it.
- R7: `irq` is a registered output. It is 1 one cycle after any unmasked primary bit (bit 23 included) is set, and it falls one cycle after none is set.
- R8: If an event pulse arrives in the same cycle as a read-clear of its status register, the read returns the old value and the event bit is set afterwards.
- R9: A pulse on `link_chg` sets all 16 secondary status bits.
- R10: Status bits whose mask bit is 1 still latch their events, but they do not raise `irq` or the summary bit.
- R11: Both mask registers read back the last value written. Read data appears on `reg_rdata` one cycle after `reg_rd`, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Local byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| ev_rx_host | input | 1 | Pulse: received frame delivered to the host |
| ev_rx_nodesc | input | 1 | Pulse: no receive descriptor was available |
| ev_tx_desc | input | 1 | Pulse: a transmit descriptor was consumed |
| ev_tx_empty | input | 1 | Pulse: the transmit queue has drained |
| mgmt_evt | input | 16 | Per-bit pulses into the secondary status |
| link_chg | input | 1 | Pulse: link state changed, sets every secondary bit |
| irq | output | 1 | Level interrupt request |

## Verification
Embedded properties check the following on every cycle:
- an event bit, once set, stays set (R2);
- a read with no write and no event leaves the status at zero (R4, R5);
- an event that coincides with a clear survives (R8);
- a link-change pulse fills the secondary register (R9);
- masks hold between writes (R11);
- a primary read while secondary work is unmasked returns bit 23 (R6);
- `irq` never rises without an unmasked cause (R7).

Some behaviour can only be shown by the bench's scenarios: the alias offsets, the reset values, the exact one-cycle latency of `irq`, the immunity of the summary to primary mask bit 23, and the read order that proves the summary survives a primary clear.

// File: rtl/irq_casc_pkg.sv
package irq_casc_pkg;
   localparam int unsigned BIT_RX_HOST   = 16;
   localparam int unsigned BIT_RX_NODESC = 17;
   localparam int unsigned BIT_SUMMARY   = 23;
   localparam int unsigned BIT_TX_DESC   = 24;
   localparam int unsigned BIT_TX_EMPTY  = 25;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_PSTAT,
      SEL_PMASK,
      SEL_SSTAT,
      SEL_SMASK
   } reg_sel_e;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
   import irq_casc_pkg::*;
#(
   parameter int unsigned   ADDR_W    = 12,
   parameter bit            ALIAS_EN  = 1'b1,
   parameter logic [ADDR_W-1:0] OFS_PSTAT = 12'h100,
   parameter logic [ADDR_W-1:0] OFS_PMASK = 12'h104,
   parameter logic [ADDR_W-1:0] OFS_PSTAT_ALT = 12'h108,
   parameter logic [ADDR_W-1:0] OFS_PMASK_ALT = 12'h10C,
   parameter logic [ADDR_W-1:0] OFS_SSTAT = 12'h018,
   parameter logic [ADDR_W-1:0] OFS_SMASK = 12'h014
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_sel_e          sel_o
);
   logic [ADDR_W-1:0] folded;

   generate
      if (ALIAS_EN) begin : g_alias
         always_comb begin
            if (addr_i == OFS_PSTAT_ALT)      folded = OFS_PSTAT;
            else if (addr_i == OFS_PMASK_ALT) folded = OFS_PMASK;
            else                              folded = addr_i;
         end
      end else begin : g_plain
         assign folded = addr_i;
      end
   endgenerate

   always_comb begin
      if (folded == OFS_PSTAT)      sel_o = SEL_PSTAT;
      else if (folded == OFS_PMASK) sel_o = SEL_PMASK;
      else if (folded == OFS_SSTAT) sel_o = SEL_SSTAT;
      else if (folded == OFS_SMASK) sel_o = SEL_SMASK;
      else                          sel_o = SEL_NONE;
   end
endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg #(
   parameter int unsigned W       = 32,
   parameter logic [W-1:0] WR_MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   input  logic         rdclr_i,
   output logic [W-1:0] stat_o
);
   logic [W-1:0] stat_q, stat_d;

   always_comb begin
      stat_d = stat_q;
      if (rdclr_i) stat_d = '0;
      if (wr_i)    stat_d = wdata_i & WR_MASK;
      stat_d = stat_d | set_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   assign stat_o = stat_q;

   p_event_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((stat_o & $past(set_i)) == $past(set_i)));

   p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rdclr_i && !wr_i && set_i == '0) |=> (stat_o == '0));

   p_collision_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rdclr_i && !wr_i && (|set_i)) |=> (stat_o == $past(set_i)));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned  W   = 32,
   parameter logic [W-1:0] RST = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] mask_o
);
   logic [W-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    mask_q <= RST;
      else if (wr_i) mask_q <= wdata_i;
   end

   assign mask_o = mask_q;

   p_mask_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
   parameter int unsigned PW      = 32,
   parameter int unsigned SW      = 16,
   parameter int unsigned SUM_POS = 23
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] pstat_i,
   input  logic [PW-1:0] pmask_i,
   input  logic [SW-1:0] sstat_i,
   input  logic [SW-1:0] smask_i,
   output logic [PW-1:0] view_o,
   output logic          irq_o
);
   localparam logic [PW-1:0] SUM_ONEHOT = PW'(1) << SUM_POS;

   logic summary, pending, irq_q;

   assign summary = |(sstat_i & ~smask_i);
   assign view_o  = pstat_i | (summary ? SUM_ONEHOT : '0);
   assign pending = (|(pstat_i & ~pmask_i & ~SUM_ONEHOT)) | summary;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= pending;
   end

   assign irq_o = irq_q;

   p_irq_needs_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pstat_i == '0 && sstat_i == '0) |=> !irq_o);

   p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((pstat_i & ~pmask_i) == '0 && (sstat_i & ~smask_i) == '0) |=> !irq_o);
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
   import irq_casc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned PW        = 32,
   parameter int unsigned SW        = 16,
   parameter bit          ALIAS_EN  = 1'b1,
   parameter logic [PW-1:0] PMASK_RST = 32'hFF7F_FFFF,
   parameter logic [SW-1:0] SMASK_RST = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [PW-1:0]     reg_wdata,
   output logic [PW-1:0]     reg_rdata,
   input  logic              ev_rx_host,
   input  logic              ev_rx_nodesc,
   input  logic              ev_tx_desc,
   input  logic              ev_tx_empty,
   input  logic [SW-1:0]     mgmt_evt,
   input  logic              link_chg,
   output logic              irq
);
   localparam logic [PW-1:0] PSTAT_WMASK = ~(PW'(1) << BIT_SUMMARY);

   generate
      if (PW <= BIT_TX_EMPTY) begin : g_bad_pw
         $error("primary width too small for event bits");
      end
      if (SW > PW || SW == 0) begin : g_bad_sw
         $error("secondary width must be 1..PW");
      end
      if (ADDR_W < 9) begin : g_bad_aw
         $error("address width cannot hold register offsets");
      end
   endgenerate

   reg_sel_e          sel;
   logic [PW-1:0]     pstat, pmask, pview, pset;
   logic [SW-1:0]     sstat, smask, sset;
   logic [PW-1:0]     rdata_q, rd_mux;

   irq_addr_decode #(
      .ADDR_W   (ADDR_W),
      .ALIAS_EN (ALIAS_EN),
      .OFS_PSTAT(ADDR_W'(12'h100)),
      .OFS_PMASK(ADDR_W'(12'h104)),
      .OFS_PSTAT_ALT(ADDR_W'(12'h108)),
      .OFS_PMASK_ALT(ADDR_W'(12'h10C)),
      .OFS_SSTAT(ADDR_W'(12'h018)),
      .OFS_SMASK(ADDR_W'(12'h014))
   ) u_dec (
      .addr_i(reg_addr),
      .sel_o (sel)
   );

   always_comb begin
      pset = '0;
      pset[BIT_RX_HOST]   = ev_rx_host;
      pset[BIT_RX_NODESC] = ev_rx_nodesc;
      pset[BIT_TX_DESC]   = ev_tx_desc;
      pset[BIT_TX_EMPTY]  = ev_tx_empty;
   end

   assign sset = mgmt_evt | {SW{link_chg}};

   irq_stat_reg #(.W(PW), .WR_MASK(PSTAT_WMASK)) u_pstat (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (pset),
      .wr_i   (reg_wr && sel == SEL_PSTAT),
      .wdata_i(reg_wdata),
      .rdclr_i(reg_rd && sel == SEL_PSTAT),
      .stat_o (pstat)
   );

   irq_stat_reg #(.W(SW), .WR_MASK('1)) u_sstat (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (sset),
      .wr_i   (reg_wr && sel == SEL_SSTAT),
      .wdata_i(reg_wdata[SW-1:0]),
      .rdclr_i(reg_rd && sel == SEL_SSTAT),
      .stat_o (sstat)
   );

   irq_mask_reg #(.W(PW), .RST(PMASK_RST)) u_pmask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (reg_wr && sel == SEL_PMASK),
      .wdata_i(reg_wdata),
      .mask_o (pmask)
   );

   irq_mask_reg #(.W(SW), .RST(SMASK_RST)) u_smask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (reg_wr && sel == SEL_SMASK),
      .wdata_i(reg_wdata[SW-1:0]),
      .mask_o (smask)
   );

   irq_merge #(.PW(PW), .SW(SW), .SUM_POS(BIT_SUMMARY)) u_merge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pstat_i(pstat),
      .pmask_i(pmask),
      .sstat_i(sstat),
      .smask_i(smask),
      .view_o (pview),
      .irq_o  (irq)
   );

   always_comb begin
      unique case (sel)
         SEL_PSTAT: rd_mux = pview;
         SEL_PMASK: rd_mux = pmask;
         SEL_SSTAT: rd_mux = PW'(sstat);
         SEL_SMASK: rd_mux = PW'(smask);
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rdata_q <= '0;
      else if (reg_rd) rdata_q <= rd_mux;
   end

   assign reg_rdata = rdata_q;

   p_link_fills_r9: assert property (@(posedge clk) disable iff (!rst_n)
      link_chg |=> (sstat == '1));

   p_summary_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && sel == SEL_PSTAT && (|(sstat & ~smask))) |=> reg_rdata[BIT_SUMMARY]);

   p_summary_survives_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && sel == SEL_PSTAT && (|(sstat & ~smask)) && !link_chg && mgmt_evt == '0)
      |=> (|(sstat & ~smask)));
endmodule

// File: tb/irq_cascade_ctrl_test.sv
module irq_cascade_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ev_rx_host = 1'b0, ev_rx_nodesc = 1'b0, ev_tx_desc = 1'b0, ev_tx_empty = 1'b0;
   logic [15:0] mgmt_evt = '0;
   logic        link_chg = 1'b0;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   irq_cascade_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ev_rx_host(ev_rx_host), .ev_rx_nodesc(ev_rx_nodesc),
      .ev_tx_desc(ev_tx_desc), .ev_tx_empty(ev_tx_empty),
      .mgmt_evt(mgmt_evt), .link_chg(link_chg), .irq(irq)
   );

   // monitor: compares read data the half-cycle after the read edge
   initial begin
      forever begin
         @(posedge clk);
         if (reg_rd && rst_n) begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
               logic [31:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               total++;
               if (reg_rdata !== e) begin
                  bad++;
                  $display("FAIL %s: rdata actual=%h expected=%h", t, reg_rdata, e);
               end
            end
         end
      end
   end

   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      reg_addr = a;
      reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      reg_addr = a;
      reg_wdata = d;
      reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      total++;
      if (irq !== e) begin
         bad++;
         $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk_irq(1'b0, "R1");
      rd(12'h104, 32'hFF7F_FFFF, "R1");
      rd(12'h014, 32'h0000_FFFF, "R1");
      rd(12'h100, 32'h0, "R1");
      rd(12'h018, 32'h0, "R1");
      // R2 / R10 masked event latches but stays quiet
      ev_rx_host = 1'b1; idle(1); ev_rx_host = 1'b0;
      idle(2);
      chk_irq(1'b0, "R10");
      rd(12'h100, 32'h0001_0000, "R2");
      rd(12'h100, 32'h0, "R4");
      // R3 alias write / readback, R11
      wr(12'h10C, 32'hFFFE_FFFF);
      rd(12'h104, 32'hFFFE_FFFF, "R3");
      rd(12'h10C, 32'hFFFE_FFFF, "R11");
      rd(12'h0F0, 32'h0, "R11");
      // R7 latency
      ev_rx_host = 1'b1; idle(1); ev_rx_host = 1'b0;
      chk_irq(1'b0, "R7");
      idle(1);
      chk_irq(1'b1, "R7");
      rd(12'h108, 32'h0001_0000, "R3");
      idle(2);
      chk_irq(1'b0, "R7");
      // R6 summary, pmask bit 23 is 1 here and must not matter
      wr(12'h014, 32'h0000_FFFE);
      mgmt_evt = 16'h0001; idle(1); mgmt_evt = '0;
      idle(2);
      chk_irq(1'b1, "R6");
      rd(12'h100, 32'h0080_0000, "R6");
      rd(12'h100, 32'h0080_0000, "R4");
      rd(12'h018, 32'h0000_0001, "R5");
      rd(12'h018, 32'h0, "R5");
      rd(12'h100, 32'h0, "R6");
      idle(2);
      chk_irq(1'b0, "R6");
      // R10 masked secondary bit
      mgmt_evt = 16'h0002; idle(1); mgmt_evt = '0;
      idle(2);
      chk_irq(1'b0, "R10");
      rd(12'h100, 32'h0, "R10");
      rd(12'h018, 32'h0000_0002, "R10");
      // R9 link change
      link_chg = 1'b1; idle(1); link_chg = 1'b0;
      rd(12'h018, 32'h0000_FFFF, "R9");
      rd(12'h100, 32'h0, "R5");
      // R8 collision, primary
      ev_tx_empty = 1'b1; idle(1); ev_tx_empty = 1'b0;
      ev_tx_desc = 1'b1;
      rd(12'h100, 32'h0200_0000, "R8");
      ev_tx_desc = 1'b0;
      rd(12'h100, 32'h0100_0000, "R8");
      // R8 collision, secondary
      mgmt_evt = 16'h0004; idle(1);
      mgmt_evt = 16'h0008;
      rd(12'h018, 32'h0000_0004, "R8");
      mgmt_evt = '0;
      rd(12'h018, 32'h0000_0008, "R8");
      // R2 all four at once
      wr(12'h104, 32'hFF7F_FFFF);
      ev_rx_host = 1'b1; ev_rx_nodesc = 1'b1; ev_tx_desc = 1'b1; ev_tx_empty = 1'b1;
      idle(1);
      ev_rx_host = 1'b0; ev_rx_nodesc = 1'b0; ev_tx_desc = 1'b0; ev_tx_empty = 1'b0;
      idle(1);
      rd(12'h100, 32'h0303_0000, "R2");
      // R6 bit 23 not writable
      wr(12'h100, 32'h0080_0001);
      rd(12'h100, 32'h0000_0001, "R6");
      idle(2);
      if (exp_q.size() != 0) begin
         bad++;
         total++;
         $display("FAIL R11: pending reads actual=%0d expected=0", exp_q.size());
      end
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule